// File: doc/BRIEF.md
# Three-wire serial EEPROM slave controller

This block is the serial-side front end of a three-wire EEPROM slave. It samples chip select, serial clock and serial data-in on a system clock, finds the rising edges of the serial clock, and frames each command: a start bit, a two-bit opcode, an address field and, for data-bearing commands, a data field. Reads are served from a word array held inside the block, and the read stream keeps going word after word for as long as the serial clock runs with chip select high.

Programming commands (single-word write, single-word erase, whole-array erase, whole-array write) are not performed here. They are handed to a separate programming sequencer as a one-cycle request carrying a command code, an address and a data word. The sequencer answers with a busy level and writes the array through a dedicated write port. While the sequencer works, data-out reports ready or busy. The word width is 16 bits (`ORG16=1`) or 8 bits (`ORG16=0`). In 8-bit mode the address field is one bit longer.

Top module: `mw_eeprom_front`

## Requirements
- R1: With chip select low, `mw_do_oe` is 0. Dropping chip select in the middle of a frame discards it: no request is issued and the array is unchanged.
- R2: Zeros on data-in before the first 1 are ignored. The first 1 sampled on a serial clock rise is the start bit. The next two bits are the opcode, MSB first: 10 read, 01 write, 11 erase, 00 extended. The address follows MSB first (6 bits by default).
- R3: On a read, the serial clock rise that shifts in the last address bit drives a 0 on data-out with `mw_do_oe` high. Each later rise drives the next bit of the addressed word, MSB first. The array holds all zeros after reset.
- R4: After the last bit of a word, the next rise drives the MSB of the word at the next address, with no new dummy bit. The address after the highest word is word 0.
- R5: Programming is disabled after reset. Extended sub-opcode 11 (the two address MSBs) enables it and 00 disables it. A write, erase, erase-all or write-all sent while disabled raises no request and leaves data-out undriven.
- R6: A write raises `prog_req` for one cycle, on the rise that shifts in the last data bit, with `prog_cmd`=0 and the frame's address and data.
- R7: An erase raises `prog_req` on the rise that shifts in the last address bit, with `prog_cmd`=1 and `prog_data` all ones.
- R8: Extended sub-opcode 10 (erase-all, `prog_cmd`=2, data all ones) launches at the last address bit. Sub-opcode 01 (write-all, `prog_cmd`=3) takes a data field and launches at its last bit. For both, the address bits below the two MSBs are ignored.
- R9: After a request, and while chip select stays high, data-out is driven with 0 while `prog_busy` or `prog_req` is high, and 1 otherwise. This lasts until a start bit is taken.
- R10: While the sequencer is busy, serial clock rises with data-in high do not start a frame. The ready indication stays on data-out afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mw_cs | input | 1 | Chip select, active high, synchronized |
| mw_sck | input | 1 | Serial clock, synchronized |
| mw_di | input | 1 | Serial data-in, synchronized |
| mw_do | output | 1 | Serial data-out value |
| mw_do_oe | output | 1 | Output enable for data-out (0 = high impedance) |
| prog_req | output | 1 | One-cycle programming request |
| prog_cmd | output | 2 | 0 write, 1 erase, 2 erase-all, 3 write-all |
| prog_addr | output | AW | Word address of the request |
| prog_data | output | WORD_W | Data word of the request |
| prog_busy | input | 1 | Sequencer busy; must rise the cycle after `prog_req` |
| seq_we | input | 1 | Sequencer write strobe into the array |
| seq_waddr | input | AW | Sequencer write address |
| seq_wdata | input | WORD_W | Sequencer write data |

## Verification
The hardest case is a start bit that arrives while programming is still running. Chip select has to stay high through the whole busy window, and the serial clock has to rise with data-in high at that time. The stimulus does exactly this after a write: it clocks ones during the busy period, waits for ready, and checks that the status indication is still driven. Without lowering chip select, it then sends a read and checks that the stream comes back correctly.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_DATA, S_READ, S_STATUS, S_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    PC_WRITE = 2'd0,
    PC_ERASE = 2'd1,
    PC_ERAL  = 2'd2,
    PC_WRAL  = 2'd3
  } prog_cmd_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] OP_EXT   = 2'b00;

  localparam logic [1:0] SUB_EN   = 2'b11;
  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WRAL = 2'b01;

  // True when the frame carries a data field after the address.
  function automatic logic takes_data(input logic [1:0] op, input logic [1:0] sub);
    return (op == OP_WRITE) || (op == OP_EXT && sub == SUB_WRAL);
  endfunction

  // True when the frame launches programming on its last address bit.
  function automatic logic fires_on_addr(input logic [1:0] op, input logic [1:0] sub);
    return (op == OP_ERASE) || (op == OP_EXT && sub == SUB_ERAL);
  endfunction

endpackage

// File: rtl/mw_sck_edge.sv
module mw_sck_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic rise
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign rise = sck & ~sck_q;

  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int AW = 6,
  parameter int WW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front
  import mw_pkg::*;
#(
  parameter int ORG16  = 1,
  parameter int ADDR_W = 6,
  localparam int WORD_W = (ORG16 != 0) ? 16 : 8,
  localparam int AW     = (ORG16 != 0) ? ADDR_W : ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mw_cs,
  input  logic              mw_sck,
  input  logic              mw_di,
  output logic              mw_do,
  output logic              mw_do_oe,
  output logic              prog_req,
  output logic [1:0]        prog_cmd,
  output logic [AW-1:0]     prog_addr,
  output logic [WORD_W-1:0] prog_data,
  input  logic              prog_busy,
  input  logic              seq_we,
  input  logic [AW-1:0]     seq_waddr,
  input  logic [WORD_W-1:0] seq_wdata
);
  localparam int CMAX = (AW > WORD_W) ? AW : WORD_W;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(WORD_W);

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  mw_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [1:0]        op_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] data_q;
  logic              wr_en_q;
  logic [AW-1:0]     ptr_q;
  logic [BW-1:0]     bit_q;
  logic              do_q;
  logic              req_q;
  prog_cmd_e         cmd_q;
  logic [AW-1:0]     paddr_q;
  logic [WORD_W-1:0] pdata_q;

  logic              sck_rise;
  logic              frame_rise;
  logic [AW-1:0]     addr_nxt;
  logic [WORD_W-1:0] data_nxt;
  logic [1:0]        sub_nxt;
  logic              addr_last;
  logic              data_last;
  logic              launch_evt;
  prog_cmd_e         launch_cmd;
  logic              busy_now;
  logic              start_seen;
  logic [WORD_W-1:0] rd_word;

  mw_sck_edge u_edge (.clk(clk), .rst_n(rst_n), .sck(mw_sck), .rise(sck_rise));

  mw_word_array #(.AW(AW), .WW(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(seq_we), .waddr(seq_waddr),
    .wdata(seq_wdata), .raddr(ptr_q), .rdata(rd_word)
  );

  assign frame_rise = mw_cs & sck_rise;
  assign addr_nxt   = {addr_q[AW-2:0], mw_di};
  assign data_nxt   = {data_q[WORD_W-2:0], mw_di};
  assign sub_nxt    = addr_nxt[AW-1 -: 2];
  assign addr_last  = frame_rise && state_q == S_ADDR && cnt_q == CW'(AW - 1);
  assign data_last  = frame_rise && state_q == S_DATA && cnt_q == CW'(WORD_W - 1);
  assign busy_now   = prog_busy | req_q;
  assign start_seen = frame_rise && mw_di && !busy_now &&
                      (state_q == S_IDLE || state_q == S_STATUS);

  always_comb begin
    launch_evt = 1'b0;
    launch_cmd = PC_WRITE;
    if (addr_last && fires_on_addr(op_q, sub_nxt)) begin
      launch_evt = 1'b1;
      launch_cmd = (op_q == OP_ERASE) ? PC_ERASE : PC_ERAL;
    end else if (data_last) begin
      launch_evt = 1'b1;
      launch_cmd = (op_q == OP_WRITE) ? PC_WRITE : PC_WRAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wr_en_q <= 1'b0;
      ptr_q   <= '0;
      bit_q   <= '0;
      do_q    <= 1'b0;
      req_q   <= 1'b0;
      cmd_q   <= PC_WRITE;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      req_q <= 1'b0;
      if (!mw_cs) begin
        state_q <= S_IDLE;
      end else if (launch_evt) begin
        if (wr_en_q) begin
          req_q   <= 1'b1;
          cmd_q   <= launch_cmd;
          paddr_q <= (launch_cmd == PC_WRITE || launch_cmd == PC_WRAL) ? addr_q : addr_nxt;
          pdata_q <= (launch_cmd == PC_WRITE || launch_cmd == PC_WRAL) ? data_nxt : '1;
          state_q <= S_STATUS;
        end else begin
          state_q <= S_HOLD;
        end
      end else if (start_seen) begin
        state_q <= S_OPC;
        cnt_q   <= '0;
      end else if (frame_rise) begin
        unique case (state_q)
          S_OPC: begin
            op_q <= {op_q[0], mw_di};
            if (cnt_q == CW'(1)) begin
              state_q <= S_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          S_ADDR: begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q + CW'(1);
            if (addr_last) begin
              cnt_q <= '0;
              if (op_q == OP_READ) begin
                state_q <= S_READ;
                ptr_q   <= addr_nxt;
                bit_q   <= BW'(WORD_W - 1);
                do_q    <= 1'b0;
              end else if (takes_data(op_q, sub_nxt)) begin
                state_q <= S_DATA;
              end else begin
                if (sub_nxt == SUB_EN)  wr_en_q <= 1'b1;
                if (sub_nxt == SUB_DIS) wr_en_q <= 1'b0;
                state_q <= S_HOLD;
              end
            end
          end
          S_DATA: begin
            data_q <= data_nxt;
            cnt_q  <= cnt_q + CW'(1);
          end
          S_READ: begin
            do_q <= rd_word[bit_q];
            if (bit_q == '0) begin
              bit_q <= BW'(WORD_W - 1);
              ptr_q <= step_ptr(ptr_q);
            end else begin
              bit_q <= bit_q - BW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mw_do     = (state_q == S_STATUS) ? ~busy_now : do_q;
  assign mw_do_oe  = mw_cs & (state_q == S_READ || state_q == S_STATUS);
  assign prog_req  = req_q;
  assign prog_cmd  = cmd_q;
  assign prog_addr = paddr_q;
  assign prog_data = pdata_q;

  // Requests only while programming is enabled.
  assert_req_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> wr_en_q);
  // Requests are single-cycle pulses.
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  // Busy is shown while the request is in flight.
  assert_busy_shown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && mw_cs) |-> (mw_do_oe && !mw_do));
  // No frame may begin while the sequencer is busy.
  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && state_q != S_OPC) |=> state_q != S_OPC);
  // A read stream opens with the dummy zero.
  assert_read_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_READ && addr_last && op_q == OP_READ) |=> (mw_do_oe && !mw_do));
  // Lowering chip select ends any drive on the next cycle.
  assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |=> (state_q == S_IDLE));
endmodule

// File: tb/mw_eeprom_front_tb_top.sv
module mw_eeprom_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 4;
  localparam int AW    = 6;
  localparam int WW    = 16;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mw_cs = 1'b0, mw_sck = 1'b0, mw_di = 1'b0;
  logic mw_do, mw_do_oe, prog_req;
  logic [1:0] prog_cmd;
  logic [AW-1:0] prog_addr;
  logic [WW-1:0] prog_data;
  logic prog_busy = 1'b0;
  logic seq_we = 1'b0;
  logic [AW-1:0] seq_waddr = '0;
  logic [WW-1:0] seq_wdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_front dut_i (
    .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sck(mw_sck), .mw_di(mw_di),
    .mw_do(mw_do), .mw_do_oe(mw_do_oe), .prog_req(prog_req), .prog_cmd(prog_cmd),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_busy(prog_busy),
    .seq_we(seq_we), .seq_waddr(seq_waddr), .seq_wdata(seq_wdata)
  );

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  logic [1:0]    last_cmd;
  logic [AW-1:0] last_addr;
  logic [WW-1:0] last_data;
  logic [WW-1:0] model [DEPTH];

  // Sequencer model: busy from the cycle after the request, writes the array.
  logic [1:0]    s_cmd;
  logic [AW-1:0] s_addr;
  logic [WW-1:0] s_data;
  int            s_k;
  always @(posedge clk) begin
    seq_we <= 1'b0;
    if (prog_req) begin
      req_cnt   <= req_cnt + 1;
      last_cmd  <= prog_cmd;
      last_addr <= prog_addr;
      last_data <= prog_data;
      s_cmd <= prog_cmd; s_addr <= prog_addr; s_data <= prog_data;
      s_k <= 0;
      prog_busy <= 1'b1;
    end else if (prog_busy) begin
      if (s_k < ((s_cmd >= 2) ? DEPTH : 1)) begin
        seq_we    <= 1'b1;
        seq_waddr <= (s_cmd >= 2) ? AW'(s_k) : s_addr;
        seq_wdata <= s_data;
      end
      s_k <= s_k + 1;
      if (s_k >= ((s_cmd >= 2) ? DEPTH : 1) + 40) prog_busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk);
    mw_di = b; mw_sck = 1'b0;
    repeat (HALF) @(negedge clk);
    mw_sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk); mw_cs = 1'b1; mw_sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk); mw_cs = 1'b0; mw_sck = 1'b0; mw_di = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [AW-1:0] a,
                            input bit with_data, input logic [WW-1:0] d);
    sbit(1'b1);
    for (int i = 1; i >= 0; i--) sbit(op[i]);
    for (int i = AW-1; i >= 0; i--) sbit(a[i]);
    if (with_data) for (int i = WW-1; i >= 0; i--) sbit(d[i]);
  endtask

  task automatic wait_ready();
    while (prog_busy || prog_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Scoreboard: expected bits queued by the driver, popped by the monitor.
  logic exp_q [$];

  task automatic read_stream(input logic [AW-1:0] a, input int nwords, input string req);
    logic e;
    send_frame(2'b10, a, 1'b0, '0);
    chk(mw_do_oe === 1'b1 && mw_do === 1'b0, {req, " dummy zero"}, {mw_do_oe, mw_do}, 2'b10);
    for (int w = 0; w < nwords; w++)
      for (int b = WW-1; b >= 0; b--) exp_q.push_back(model[(int'(a) + w) % DEPTH][b]);
    while (exp_q.size() > 0) begin
      sbit(1'b0);
      e = exp_q.pop_front();
      chk(mw_do === e && mw_do_oe === 1'b1, req, mw_do, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk(mw_do_oe === 1'b0 && prog_req === 1'b0, "R1 reset", {mw_do_oe, prog_req}, 0);

    // R5: write while disabled
    cs_on();
    send_frame(2'b01, 6'd5, 1'b1, 16'h1111);
    repeat (3) @(negedge clk);
    chk(req_cnt == 0, "R5 no request when disabled", req_cnt, 0);
    chk(mw_do_oe === 1'b0, "R5 no status when disabled", mw_do_oe, 0);
    cs_off();

    // R5: enable
    cs_on(); send_frame(2'b00, 6'b110000, 1'b0, '0); cs_off();

    // R2 leading zeros, R6 write, R9 busy/ready, R10 start ignored while busy
    cs_on();
    sbit(1'b0); sbit(1'b0); sbit(1'b0);
    send_frame(2'b01, 6'd5, 1'b1, 16'hA5C3);
    model[5] = 16'hA5C3;
    chk(req_cnt == 1, "R6 write request", req_cnt, 1);
    chk(last_cmd == 2'd0 && last_addr == 6'd5 && last_data == 16'hA5C3, "R6 write fields",
        {14'd0, last_cmd, last_addr, last_data[7:0]}, {16'd0, 6'd5, 8'hC3});
    chk(mw_do_oe === 1'b1 && mw_do === 1'b0, "R9 busy shown", {mw_do_oe, mw_do}, 2'b10);
    sbit(1'b1); sbit(1'b1); sbit(1'b1);
    wait_ready();
    chk(mw_do_oe === 1'b1 && mw_do === 1'b1, "R10 ready still shown after busy start bits",
        {mw_do_oe, mw_do}, 2'b11);
    read_stream(6'd5, 1, "R9 read after status");
    cs_off();

    cs_on(); send_frame(2'b01, 6'd63, 1'b1, 16'h8001); model[63] = 16'h8001; wait_ready(); cs_off();
    cs_on(); send_frame(2'b01, 6'd6, 1'b1, 16'h0F0F);  model[6] = 16'h0F0F;  wait_ready(); cs_off();

    // R3, R4: sequential read and wrap
    cs_on(); read_stream(6'd5, 2, "R4 sequential"); cs_off();
    cs_on(); read_stream(6'd63, 2, "R4 wrap"); cs_off();
    cs_on(); read_stream(6'd20, 1, "R3 zero after reset"); cs_off();

    // R7: erase
    cs_on(); send_frame(2'b11, 6'd6, 1'b0, '0);
    chk(last_cmd == 2'd1 && last_addr == 6'd6 && last_data == 16'hFFFF, "R7 erase fields",
        {last_cmd, last_addr, last_data}, {2'd1, 6'd6, 16'hFFFF});
    model[6] = 16'hFFFF; wait_ready(); cs_off();
    cs_on(); read_stream(6'd6, 1, "R7 erased word"); cs_off();

    // R1: abort mid frame
    rc = req_cnt;
    cs_on(); sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); cs_off();
    chk(req_cnt == rc && mw_do_oe === 1'b0, "R1 abort", req_cnt, rc);
    cs_on(); read_stream(6'd5, 1, "R1 array unchanged"); cs_off();

    // R8: write-all with don't-care address bits
    cs_on(); send_frame(2'b00, 6'b011010, 1'b1, 16'h1234);
    chk(last_cmd == 2'd3 && last_data == 16'h1234, "R8 write-all fields",
        {last_cmd, last_data}, {2'd3, 16'h1234});
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h1234;
    wait_ready(); cs_off();
    cs_on(); read_stream(6'd9, 1, "R8 write-all content"); cs_off();

    // R8: erase-all
    cs_on(); send_frame(2'b00, 6'b100110, 1'b0, '0);
    chk(last_cmd == 2'd2 && last_data == 16'hFFFF, "R8 erase-all fields",
        {last_cmd, last_data}, {2'd2, 16'hFFFF});
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    wait_ready(); cs_off();
    cs_on(); read_stream(6'd0, 1, "R8 erase-all content"); cs_off();

    // R5: disable then erase attempt
    cs_on(); send_frame(2'b00, 6'b001111, 1'b0, '0); cs_off();
    rc = req_cnt;
    cs_on(); send_frame(2'b11, 6'd2, 1'b0, '0); repeat (3) @(negedge clk);
    chk(req_cnt == rc && mw_do_oe === 1'b0, "R5 disabled erase", req_cnt, rc);
    cs_off();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule